// File: doc/BRIEF.md
# Pipelined Log-Likelihood Score Accumulator

This block scores one candidate position of a scintillation event for a maximum-likelihood positioning search. A channel sequencer presents one sensor channel per clock. Each presentation carries the measured channel energy and three coefficients taken from characterization tables: the expected mean response, a gain equal to the reciprocal of sigma times the square root of two, and an offset equal to the logarithm of sigma. The host computes the gain and the offset ahead of time. As a result the datapath has no divider and no logarithm unit. Each channel term costs one subtraction, two multiplications and one addition.

Every value is an integer, and fractional coefficients arrive already scaled by a power of two. The block forms the term square(((energy - mean) * gain) >>> SHIFT) + offset. It adds the terms of one evaluation into a saturating accumulator. When the sequencer flags the last channel, the block presents the finished score with a one-cycle strobe, which a downstream minimum finder compares across candidates. The pipeline has three register stages: subtract, scale, then square and accumulate.

Top module: `nll_term_accum`

## Requirements
- R1: For each channel with `in_valid` high, the term added is sq + C. Here d = E - A is signed. p = d * B, with B taken as unsigned. s = p >>> SHIFT is an arithmetic shift that rounds toward minus infinity, and sq = s * s. A negative d gives the same square as its magnitude only where the shift is exact.
- R2: A channel with `in_first` high starts a new evaluation. The sum of any earlier evaluation is discarded and the score is the sum of the terms from that channel through the channel marked `in_last`.
- R3: Cycles with `in_valid` low add nothing to the sum. Their `in_first` and `in_last` values are ignored.
- R4: `score_valid` is high for exactly one cycle, three clock edges after the edge that samples a valid channel with `in_last` high, and at no other time.
- R5: The score saturates at 2^ACC_W - 1 (2^48 - 1 by default) instead of wrapping, and it stays there for the rest of that evaluation.
- R6: A channel with both `in_first` and `in_last` high forms a one-channel evaluation whose score is that single term.
- R7: An evaluation may begin in the cycle right after the previous `in_last`, and each score then belongs to its own evaluation.
- R8: While `rst_n` is low, and in the cycle after it rises, `score_valid` is 0 and `score` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A channel is presented this cycle |
| in_first | input | 1 | First channel of an evaluation |
| in_last | input | 1 | Last channel of an evaluation |
| in_energy | input | E_W (16) | Measured channel energy, unsigned |
| in_mean | input | COEF_W (16) | Mean coefficient A, unsigned |
| in_gain | input | COEF_W (16) | Gain coefficient B, unsigned |
| in_offset | input | COEF_W (16) | Offset coefficient C, unsigned |
| score_valid | output | 1 | Score strobe |
| score | output | ACC_W (48) | Accumulated score |

## Verification
A sweep of single-channel evaluations crosses edge values of energy, mean, gain and offset. Energies above and below the mean separate the sign handling and the floor behaviour of the arithmetic shift. A gain of zero isolates the offset path. Randomized evaluations of 1 to 21 channels, run back to back and with idle gaps that carry stray markers, show whether the first marker clears the sum and whether idle cycles leak into it. Runs of full-scale channels drive the sum past its limit, which separates clamping from wrap-around.

// File: rtl/nll_pkg.sv
// Shared types for the log-likelihood score accumulator.
package nll_pkg;
    // Control markers that travel alongside the data through each stage.
    typedef struct packed {
        logic vld;
        logic first;
        logic last;
    } nll_tag_t;
endpackage

// File: rtl/nll_diff_stage.sv
// Stage 1: registers the signed difference energy - mean and carries the
// gain, offset and markers forward. Assumes both operands are unsigned.
module nll_diff_stage
    import nll_pkg::*;
#(
    parameter int E_W    = 16,
    parameter int COEF_W = 16,
    parameter int D_W    = ((E_W > COEF_W) ? E_W : COEF_W) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  nll_tag_t                 tag_in,
    input  logic [E_W-1:0]           energy,
    input  logic [COEF_W-1:0]        mean,
    input  logic [COEF_W-1:0]        gain,
    input  logic [COEF_W-1:0]        offset,
    output nll_tag_t                 tag_q,
    output logic signed [D_W-1:0]    diff_q,
    output logic [COEF_W-1:0]        gain_q,
    output logic [COEF_W-1:0]        offset_q
);
    logic signed [D_W-1:0] diff_d;

    // Zero-extend both operands and subtract at full signed width.
    always_comb begin
        diff_d = $signed({{(D_W-E_W){1'b0}}, energy})
               - $signed({{(D_W-COEF_W){1'b0}}, mean});
    end

    // Capture the difference and the forwarded fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q    <= '0;
            diff_q   <= '0;
            gain_q   <= '0;
            offset_q <= '0;
        end else begin
            tag_q    <= tag_in;
            diff_q   <= diff_d;
            gain_q   <= gain;
            offset_q <= offset;
        end
    end
endmodule

// File: rtl/nll_scale_stage.sv
// Stage 2: multiplies the difference by the unsigned gain and applies a fixed
// arithmetic right shift. Assumes SHIFT is less than the product width.
module nll_scale_stage
    import nll_pkg::*;
#(
    parameter int D_W    = 17,
    parameter int COEF_W = 16,
    parameter int SHIFT  = 8,
    parameter int P_W    = D_W + COEF_W + 1,
    parameter int S_W    = P_W - SHIFT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  nll_tag_t                 tag_in,
    input  logic signed [D_W-1:0]    diff,
    input  logic [COEF_W-1:0]        gain,
    input  logic [COEF_W-1:0]        offset,
    output nll_tag_t                 tag_q,
    output logic signed [S_W-1:0]    scaled_q,
    output logic [COEF_W-1:0]        offset_q
);
    logic signed [P_W-1:0] diff_ext;
    logic signed [P_W-1:0] gain_ext;
    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] shifted;

    // Widen both operands, multiply exactly and drop SHIFT fraction bits.
    always_comb begin
        diff_ext = P_W'(diff);
        gain_ext = $signed({{(P_W-COEF_W){1'b0}}, gain});
        prod     = diff_ext * gain_ext;
        shifted  = prod >>> SHIFT;
    end

    // Capture the scaled product and the forwarded fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q    <= '0;
            scaled_q <= '0;
            offset_q <= '0;
        end else begin
            tag_q    <= tag_in;
            scaled_q <= shifted[S_W-1:0];
            offset_q <= offset;
        end
    end
endmodule

// File: rtl/nll_accum_stage.sv
// Stage 3: squares the scaled value, adds the offset and accumulates with
// saturation. A first marker replaces the running sum. The strobe follows a
// last marker. Assumes markers only matter when vld is set.
module nll_accum_stage
    import nll_pkg::*;
#(
    parameter int S_W    = 26,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 48,
    parameter int SQ_W   = 2 * S_W,
    parameter int SUM_W  = ((SQ_W > ACC_W) ? SQ_W : ACC_W) + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  nll_tag_t                 tag_in,
    input  logic signed [S_W-1:0]    scaled,
    input  logic [COEF_W-1:0]        offset,
    output logic                     done_q,
    output logic [ACC_W-1:0]         acc_q
);
    localparam logic [SUM_W-1:0] ACC_MAX = {{(SUM_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};

    logic signed [SQ_W-1:0] sc_ext;
    logic signed [SQ_W-1:0] sq_s;
    logic [SUM_W-1:0]       term;
    logic [SUM_W-1:0]       base;
    logic [SUM_W-1:0]       total;
    logic [ACC_W-1:0]       acc_d;

    // Build the channel term and the clamped running sum.
    always_comb begin
        sc_ext = SQ_W'(scaled);
        sq_s   = sc_ext * sc_ext;
        term   = {{(SUM_W-SQ_W){1'b0}}, $unsigned(sq_s)}
               + {{(SUM_W-COEF_W){1'b0}}, offset};
        base   = tag_in.first ? '0 : {{(SUM_W-ACC_W){1'b0}}, acc_q};
        total  = base + term;
        acc_d  = (total > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : total[ACC_W-1:0];
    end

    // Update the sum on valid channels and raise the strobe after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (tag_in.vld) begin
                acc_q <= acc_d;
            end
            done_q <= tag_in.vld & tag_in.last;
        end
    end
endmodule

// File: rtl/nll_term_accum.sv
// Top level: three-stage pipeline that scores one candidate position as the
// sum over channels of square(((E - A) * B) >>> SHIFT) + C. Assumes that the
// coefficients arrive already scaled to integers and that the caller
// brackets each evaluation with first and last markers.
module nll_term_accum
    import nll_pkg::*;
#(
    parameter int E_W    = 16,
    parameter int COEF_W = 16,
    parameter int SHIFT  = 8,
    parameter int ACC_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [E_W-1:0]    in_energy,
    input  logic [COEF_W-1:0] in_mean,
    input  logic [COEF_W-1:0] in_gain,
    input  logic [COEF_W-1:0] in_offset,
    output logic              score_valid,
    output logic [ACC_W-1:0]  score
);
    localparam int D_W = ((E_W > COEF_W) ? E_W : COEF_W) + 1;
    localparam int P_W = D_W + COEF_W + 1;
    localparam int S_W = P_W - SHIFT;

    nll_tag_t              tag_in;
    nll_tag_t              tag1;
    nll_tag_t              tag2;
    logic signed [D_W-1:0] diff1;
    logic [COEF_W-1:0]     gain1;
    logic [COEF_W-1:0]     off1;
    logic signed [S_W-1:0] scaled2;
    logic [COEF_W-1:0]     off2;

    // Qualify the markers with the channel valid.
    always_comb begin
        tag_in.vld   = in_valid;
        tag_in.first = in_valid & in_first;
        tag_in.last  = in_valid & in_last;
    end

    nll_diff_stage #(.E_W(E_W), .COEF_W(COEF_W), .D_W(D_W)) u_diff (
        .clk(clk), .rst_n(rst_n), .tag_in(tag_in),
        .energy(in_energy), .mean(in_mean), .gain(in_gain), .offset(in_offset),
        .tag_q(tag1), .diff_q(diff1), .gain_q(gain1), .offset_q(off1)
    );

    nll_scale_stage #(.D_W(D_W), .COEF_W(COEF_W), .SHIFT(SHIFT), .P_W(P_W), .S_W(S_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .tag_in(tag1),
        .diff(diff1), .gain(gain1), .offset(off1),
        .tag_q(tag2), .scaled_q(scaled2), .offset_q(off2)
    );

    nll_accum_stage #(.S_W(S_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .tag_in(tag2),
        .scaled(scaled2), .offset(off2),
        .done_q(score_valid), .acc_q(score)
    );
endmodule

// File: rtl/nll_term_accum_chk.sv
// Checker for nll_term_accum: relates the strobe to the last marker seen at
// the inputs and keeps the score defined. It counts edges since reset so
// that no property reaches back across reset.
module nll_term_accum_chk #(
    parameter int ACC_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_last,
    input logic             score_valid,
    input logic [ACC_W-1:0] score
);
    logic [1:0] warm;

    // Count edges since reset, stopping at three.
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R4
    strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && score_valid) |-> $past(in_valid && in_last, 3));

    // R4
    cause_gives_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(in_valid && in_last, 3)) |-> score_valid);

    // R8
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd3) |-> !score_valid);

    // R1
    score_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |-> !$isunknown(score));
endmodule

bind nll_term_accum nll_term_accum_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .score_valid(score_valid), .score(score)
);

// File: tb/nll_term_accum_tb.sv
// Self-checking bench: edge-value sweep of single-channel scores, random
// multi-channel evaluations with gaps and stray markers, and saturation runs.
module nll_term_accum_tb;
    localparam int  SHIFT = 8;
    localparam int  ACC_W = 48;
    localparam longint ACC_MAX = (64'd1 << ACC_W) - 1;
    localparam int  LIMIT = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [15:0]       in_energy = '0, in_mean = '0, in_gain = '0, in_offset = '0;
    logic              score_valid;
    logic [ACC_W-1:0]  score;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    longint exp_q [0:1023];
    int     lat_q [0:1023];
    string  tag_q [0:1023];
    int     wr = 0, rd = 0;

    int ev_e [0:31];
    int ev_a [0:31];
    int ev_b [0:31];
    int ev_c [0:31];

    nll_term_accum #(.SHIFT(SHIFT), .ACC_W(ACC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_energy(in_energy), .in_mean(in_mean),
        .in_gain(in_gain), .in_offset(in_offset),
        .score_valid(score_valid), .score(score)
    );

    always #4 clk = ~clk;

    // Edge counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT && !done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic longint term_of(int e, int a, int b, int c);
        longint d, p, s;
        d = longint'(e) - longint'(a);
        p = d * longint'(b);
        s = p >>> SHIFT;
        return s * s + longint'(c);
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare every strobe against the queued expectation and its latency (R4).
    always @(negedge clk) begin
        if (rst_n && score_valid) begin
            if (rd == wr) begin
                check("R4 unexpected strobe", 1, 0);
            end else begin
                check(tag_q[rd % 1024], longint'(score), exp_q[rd % 1024]);
                check("R4 latency", longint'(cyc - lat_q[rd % 1024]), 3);
                rd = rd + 1;
            end
        end
    end

    task automatic idle(int n, bit junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_first  = junk ? 1'($urandom) : 1'b0;
            in_last   = junk ? 1'($urandom) : 1'b0;
            in_energy = 16'($urandom);
            in_mean   = 16'($urandom);
            in_gain   = 16'($urandom);
            in_offset = 16'($urandom);
        end
    endtask

    // Drive ev_* [0..n-1] as one evaluation; gaps insert idle cycles with stray markers (R3).
    task automatic run_eval(int n, bit gaps, string req);
        longint acc = 0;
        for (int i = 0; i < n; i++) begin
            acc = acc + term_of(ev_e[i], ev_a[i], ev_b[i], ev_c[i]);
            if (acc > ACC_MAX) acc = ACC_MAX;
        end
        exp_q[wr % 1024] = acc;
        tag_q[wr % 1024] = req;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_first  = (i == 0);
            in_last   = (i == n - 1);
            in_energy = 16'(ev_e[i]);
            in_mean   = 16'(ev_a[i]);
            in_gain   = 16'(ev_b[i]);
            in_offset = 16'(ev_c[i]);
            if (i == n - 1) begin
                lat_q[wr % 1024] = cyc;
                wr = wr + 1;
            end
            if (gaps && i != n - 1 && ($urandom % 3 == 0)) idle(1 + int'($urandom % 3), 1'b1);
        end
    endtask

    function automatic int edge_val(int k);
        case (k)
            0: return 0;
            1: return 1;
            2: return 32767;
            default: return 65535;
        endcase
    endfunction

    function automatic int gain_val(int k);
        case (k)
            0: return 0;
            1: return 1;
            2: return 255;
            default: return 65535;
        endcase
    endfunction

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset valid", longint'(score_valid), 0);
        check("R8 reset score", longint'(score), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 post-reset valid", longint'(score_valid), 0);
        check("R8 post-reset score", longint'(score), 0);

        // R1, R6, R7: single-channel sweep over edge values, back to back
        for (int ie = 0; ie < 4; ie++)
            for (int ia = 0; ia < 4; ia++)
                for (int ib = 0; ib < 4; ib++)
                    for (int ic = 0; ic < 2; ic++) begin
                        ev_e[0] = edge_val(ie);
                        ev_a[0] = edge_val(ia);
                        ev_b[0] = gain_val(ib);
                        ev_c[0] = ic ? 65535 : 0;
                        run_eval(1, 1'b0, "R1 R6 single-channel term");
                    end
        idle(5, 1'b1);

        // R2, R3, R7: random evaluations of 1..21 channels, with and without gaps
        for (int k = 0; k < 300; k++) begin
            int n = 1 + int'($urandom % 21);
            for (int i = 0; i < n; i++) begin
                ev_e[i] = int'($urandom % 65536);
                ev_a[i] = int'($urandom % 65536);
                ev_b[i] = int'($urandom % 4096);
                ev_c[i] = int'($urandom % 65536);
            end
            run_eval(n, k[0], "R2 R3 R7 random sum");
            if (k % 4 == 3) idle(1 + int'($urandom % 4), 1'b1);
        end

        // R5: saturation at full scale, then a small evaluation clears it (R2)
        for (int i = 0; i < 21; i++) begin
            ev_e[i] = 65535; ev_a[i] = 0; ev_b[i] = 65535; ev_c[i] = 65535;
        end
        run_eval(21, 1'b0, "R5 saturation 21ch");
        run_eval(2, 1'b1, "R5 saturation 2ch");
        ev_e[0] = 10; ev_a[0] = 3; ev_b[0] = 512; ev_c[0] = 7;
        run_eval(1, 1'b0, "R2 restart after saturation");
        idle(8, 1'b0);

        check("R4 all strobes seen", longint'(rd), longint'(wr));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule